// File: doc/BRIEF.md
# Return Address Hash Digest Engine

This block computes a 64-bit digest that binds two 64-bit operands to a 64-bit secret key. A processor uses it to protect return addresses. On function entry it stores the digest next to the saved address. On return it recomputes the digest and compares it with the stored copy. A compare failure raises a trap indication.

The operands are first byte-interleaved into two 64-bit words. Each word is split into two 32-bit blocks. The four blocks are enciphered in parallel by four instances of a small Feistel cipher. The cipher has 16-bit halves, 32 rounds, and a key schedule expanded from the 64-bit key. Each instance rotates the order of the key words inside every group of four rounds by a different amount. The two 64-bit cipher results are folded together by XOR.

The engine is iterative. It performs one round for all four lanes in each cycle, and it expands the key schedule one word per cycle alongside the rounds. A one-cycle `start` captures all inputs. The engine then runs for a fixed number of cycles and ends with a one-cycle `done`.

Top module: `rahash_engine`

## Requirements
- R1: After reset, `busy`, `done`, `mismatch` and `digest` are all 0.
- R2: The interleaved word H places bytes 0,1,2,3 of B at byte positions 7,5,3,1 and bytes 4,5,6,7 of A at positions 0,2,4,6. The interleaved word L places bytes 4,5,6,7 of B at positions 7,5,3,1 and bytes 0,1,2,3 of A at positions 0,2,4,6. Byte 0 is bits 7:0. Lanes 0 and 1 encipher H bits 63:32 and H bits 31:0, and lanes 2 and 3 encipher L bits 63:32 and L bits 31:0. The digest is {lane0,lane1} XOR {lane2,lane3}.
- R3: The cipher treats a block as left = bits 15:0 and right = bits 31:16, and it runs 32 rounds. Each round sets left to right ^ ((rotl(left,1) & rotl(left,8)) ^ rotl(left,2)) ^ roundkey, and sets right to the old left. The cipher output is {right,left}.
- R4: Key word k0 is key bits 63:48 and k3 is key bits 15:0. For i from 0 to 27, t = rotr(k[i+3],3) ^ k[i+1] and k[i+4] = 0xFFFC ^ z ^ k[i] ^ t ^ rotr(t,1), where z is bit 63-i of 0xFA2561CDF44AC398. Lane n uses k[4g + ((j+n) mod 4)] in round 4g+j.
- R5: In check mode (`checkMode`=1), `mismatch` is 1 after completion exactly when the digest differs from `expectVal`.
- R6: In store mode (`checkMode`=0), `mismatch` stays 0 whatever the value of `expectVal`.
- R7: A `start` sampled while idle is accepted. `busy` is high in the following cycle, and `done` is a single-cycle pulse 33 cycles after the accepting edge. All operands are captured at that edge, so later input changes have no effect.
- R8: A `start` sampled while `busy` is high is ignored. It changes neither the result nor the completion cycle.
- R9: `digest` and `mismatch` hold after `done` until the next accepted `start`, which clears both to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a computation (accepted only when idle) |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| hashKey | input | 64 | Secret key |
| checkMode | input | 1 | 1 = compare against expectVal, 0 = store |
| expectVal | input | 64 | Value compared in check mode |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| digest | output | 64 | Computed digest |
| mismatch | output | 1 | Check-mode compare failure |

## Verification
The bench computes the digest with its own software model and checks it on directed and random operands. A wrong byte interleave, lane assignment, key rotation or schedule constant corrupts the digest on nearly every random vector. The bench flips one bit of the expected value to catch a compare that ignores some bits. It also feeds a mismatching value in store mode, which a design that flags regardless of mode would report. Further checks cover a `start` pulse in the middle of a run and operand changes after acceptance; a design that restarts or samples late would move `done` or alter the digest. The bench also confirms that results hold after `done` and clear on the next start.

// File: rtl/rahash_pkg.sv
`timescale 1ns/1ps
package rahash_pkg;
  localparam int HALF_W     = 16;
  localparam int BLOCK_W    = 2 * HALF_W;
  localparam int WORD_W     = 64;
  localparam int NUM_LANES  = 4;
  localparam int KEY_WORDS  = 4;
  localparam int NUM_ROUNDS = 32;
  localparam int RND_W      = $clog2(NUM_ROUNDS);
  localparam int GRP_W      = $clog2(KEY_WORDS);
  localparam logic [63:0]       Z_SEQ   = 64'hFA2561CDF44AC398;
  localparam logic [HALF_W-1:0] SCHED_C = 16'hFFFC;

  typedef logic [HALF_W-1:0] half_t;

  typedef struct packed {
    logic             load;
    logic             step;
    logic             fold;
    logic [RND_W-1:0] rnd;
  } dpCtrl_t;

  function automatic half_t rotl16(input half_t v, input int n);
    return (v << n) | (v >> (HALF_W - n));
  endfunction

  function automatic half_t rotr16(input half_t v, input int n);
    return (v >> n) | (v << (HALF_W - n));
  endfunction
endpackage

// File: rtl/rahash_ctrl.sv
`timescale 1ns/1ps
module rahash_ctrl
  import rahash_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output logic    busy,
  output logic    done,
  output dpCtrl_t ctl
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FOLD} state_t;

  localparam logic [RND_W-1:0] LAST_RND = RND_W'(NUM_ROUNDS - 1);

  state_t           state;
  logic [RND_W-1:0] rndCnt;
  logic             doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      rndCnt <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state  <= ST_RUN;
          rndCnt <= '0;
        end
        ST_RUN: begin
          rndCnt <= rndCnt + 1'b1;
          if (rndCnt == LAST_RND) state <= ST_FOLD;
        end
        ST_FOLD: begin
          state <= ST_IDLE;
          doneQ <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load = (state == ST_IDLE) && start;
    ctl.step = (state == ST_RUN);
    ctl.fold = (state == ST_FOLD);
    ctl.rnd  = rndCnt;
  end

  assign busy = (state != ST_IDLE);
  assign done = doneQ;
endmodule

// File: rtl/rahash_dpath.sv
`timescale 1ns/1ps
module rahash_dpath
  import rahash_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic [WORD_W-1:0] hashKey,
  input  logic              checkMode,
  input  logic [WORD_W-1:0] expectVal,
  output logic [WORD_W-1:0] digest,
  output logic              mismatch
);
  localparam int BYTES_HALF = WORD_W / 16;

  // byte interleave of the operands
  logic [WORD_W-1:0] mixH, mixL;
  always_comb begin
    mixH = '0;
    mixL = '0;
    for (int b = 0; b < BYTES_HALF; b++) begin
      mixH[8*(7-2*b) +: 8] = opB[8*b +: 8];
      mixH[8*(2*b)   +: 8] = opA[8*(BYTES_HALF+b) +: 8];
      mixL[8*(7-2*b) +: 8] = opB[8*(BYTES_HALF+b) +: 8];
      mixL[8*(2*b)   +: 8] = opA[8*b +: 8];
    end
  end

  logic [BLOCK_W-1:0] laneIn [NUM_LANES];
  assign laneIn[0] = mixH[WORD_W-1:BLOCK_W];
  assign laneIn[1] = mixH[BLOCK_W-1:0];
  assign laneIn[2] = mixL[WORD_W-1:BLOCK_W];
  assign laneIn[3] = mixL[BLOCK_W-1:0];

  // incremental key schedule: slide holds k[r..r+3], grp holds the current group
  half_t slideQ [KEY_WORDS];
  half_t grpQ   [KEY_WORDS];
  half_t keyWord [KEY_WORDS];
  half_t schedT, schedNew;
  logic  zBit;
  logic [5:0] zIdx;

  always_comb begin
    for (int w = 0; w < KEY_WORDS; w++)
      keyWord[w] = hashKey[WORD_W-1-HALF_W*w -: HALF_W];
    zIdx     = 6'd63 - 6'(ctl.rnd);
    zBit     = Z_SEQ[zIdx];
    schedT   = rotr16(slideQ[3], 3) ^ slideQ[1];
    schedNew = SCHED_C ^ {{(HALF_W-1){1'b0}}, zBit} ^ slideQ[0]
               ^ schedT ^ rotr16(schedT, 1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < KEY_WORDS; w++) begin
        slideQ[w] <= '0;
        grpQ[w]   <= '0;
      end
    end else if (ctl.load) begin
      for (int w = 0; w < KEY_WORDS; w++) begin
        slideQ[w] <= keyWord[w];
        grpQ[w]   <= keyWord[w];
      end
    end else if (ctl.step) begin
      for (int w = 0; w < KEY_WORDS-1; w++) slideQ[w] <= slideQ[w+1];
      slideQ[KEY_WORDS-1] <= schedNew;
      if (ctl.rnd[GRP_W-1:0] == GRP_W'(KEY_WORDS-1)) begin
        for (int w = 0; w < KEY_WORDS-1; w++) grpQ[w] <= slideQ[w+1];
        grpQ[KEY_WORDS-1] <= schedNew;
      end
    end
  end

  // four Feistel lanes
  logic [BLOCK_W-1:0] laneOut [NUM_LANES];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    half_t leftQ, rightQ, fVal, rKey;
    logic [GRP_W-1:0] kSel;
    always_comb begin
      kSel = ctl.rnd[GRP_W-1:0] + GRP_W'(g);
      rKey = grpQ[kSel];
      fVal = (rotl16(leftQ, 1) & rotl16(leftQ, 8)) ^ rotl16(leftQ, 2);
    end
    always_ff @(posedge clk) begin
      if (!rstN) begin
        leftQ  <= '0;
        rightQ <= '0;
      end else if (ctl.load) begin
        leftQ  <= laneIn[g][HALF_W-1:0];
        rightQ <= laneIn[g][BLOCK_W-1:HALF_W];
      end else if (ctl.step) begin
        leftQ  <= rightQ ^ fVal ^ rKey;
        rightQ <= leftQ;
      end
    end
    assign laneOut[g] = {rightQ, leftQ};
  end

  // fold, compare and result registers
  logic              modeQ;
  logic [WORD_W-1:0] expQ, foldVal, digestQ;
  logic              mismatchQ;

  assign foldVal = {laneOut[0], laneOut[1]} ^ {laneOut[2], laneOut[3]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ     <= 1'b0;
      expQ      <= '0;
      digestQ   <= '0;
      mismatchQ <= 1'b0;
    end else if (ctl.load) begin
      modeQ     <= checkMode;
      expQ      <= expectVal;
      digestQ   <= '0;
      mismatchQ <= 1'b0;
    end else if (ctl.fold) begin
      digestQ   <= foldVal;
      mismatchQ <= modeQ && (foldVal != expQ);
    end
  end

  assign digest   = digestQ;
  assign mismatch = mismatchQ;
endmodule

// File: rtl/rahash_engine.sv
`timescale 1ns/1ps
module rahash_engine
  import rahash_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [63:0] opA,
  input  logic [63:0] opB,
  input  logic [63:0] hashKey,
  input  logic        checkMode,
  input  logic [63:0] expectVal,
  output logic        busy,
  output logic        done,
  output logic [63:0] digest,
  output logic        mismatch
);
  dpCtrl_t ctl;

  rahash_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .busy  (busy),
    .done  (done),
    .ctl   (ctl)
  );

  rahash_dpath u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .opA       (opA),
    .opB       (opB),
    .hashKey   (hashKey),
    .checkMode (checkMode),
    .expectVal (expectVal),
    .digest    (digest),
    .mismatch  (mismatch)
  );
endmodule

// File: rtl/rahash_checker.sv
`timescale 1ns/1ps
module rahash_checker
  import rahash_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        checkMode,
  input logic        busy,
  input logic        done,
  input logic [63:0] digest,
  input logic        mismatch
);
  localparam int LATENCY = NUM_ROUNDS + 1;

  logic       modeSeen;
  logic [7:0] busyCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeSeen <= 1'b0;
      busyCnt  <= '0;
    end else if (start && !busy) begin
      modeSeen <= checkMode;
      busyCnt  <= '0;
    end else if (busy) begin
      busyCnt <= busyCnt + 1'b1;
    end
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_busy_after_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busyCnt == 8'(LATENCY)));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (busy || done));

  assert_store_clean_R6: assert property (@(posedge clk) disable iff (!rstN)
    (done && !modeSeen) |-> !mismatch);

  assert_mismatch_at_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mismatch) |-> done);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(digest) && $stable(mismatch)));
endmodule

bind rahash_engine rahash_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .checkMode (checkMode),
  .busy      (busy),
  .done      (done),
  .digest    (digest),
  .mismatch  (mismatch)
);

// File: tb/rahash_engine_bench.sv
`timescale 1ns/1ps
module rahash_engine_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [63:0] opA = '0, opB = '0, hashKey = '0, expectVal = '0;
  logic        checkMode = 1'b0;
  logic        busy, done, mismatch;
  logic [63:0] digest;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rahash_engine u_rahash_engine (
    .clk(clk), .rstN(rstN), .start(start), .opA(opA), .opB(opB),
    .hashKey(hashKey), .checkMode(checkMode), .expectVal(expectVal),
    .busy(busy), .done(done), .digest(digest), .mismatch(mismatch)
  );

  localparam logic [63:0] ZC = 64'hFA2561CDF44AC398;

  function automatic logic [31:0] refCipher(input logic [31:0] x, input logic [63:0] key, input int lane);
    logic [15:0] k [32];
    logic [15:0] l, r, t, f, nl;
    for (int i = 0; i < 4; i++) k[i] = key[63-16*i -: 16];
    for (int i = 0; i < 28; i++) begin
      t = {k[i+3][2:0], k[i+3][15:3]} ^ k[i+1];
      k[i+4] = 16'hFFFC ^ {15'b0, ZC[63-i]} ^ k[i] ^ t ^ {t[0], t[15:1]};
    end
    l = x[15:0];
    r = x[31:16];
    for (int i = 0; i < 32; i++) begin
      f  = ({l[14:0], l[15]} & {l[7:0], l[15:8]}) ^ {l[13:0], l[15:14]};
      nl = r ^ f ^ k[4*(i/4) + ((i%4 + lane) % 4)];
      r  = l;
      l  = nl;
    end
    return {r, l};
  endfunction

  function automatic logic [63:0] refHash(input logic [63:0] a, input logic [63:0] b, input logic [63:0] key);
    logic [63:0] h, lw;
    for (int n = 0; n < 4; n++) begin
      h[8*(7-2*n) +: 8]  = b[8*n +: 8];
      h[16*n +: 8]       = a[32+8*n +: 8];
      lw[8*(7-2*n) +: 8] = b[32+8*n +: 8];
      lw[16*n +: 8]      = a[8*n +: 8];
    end
    return {refCipher(h[63:32], key, 0), refCipher(h[31:0], key, 1)} ^
           {refCipher(lw[63:32], key, 2), refCipher(lw[31:0], key, 3)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic doOp(input logic [63:0] a, input logic [63:0] b, input logic [63:0] k,
                      input logic m, input logic [63:0] e, input bit poke);
    logic [63:0] refD, held;
    logic heldM;
    int c;
    refD = refHash(a, b, k);
    @(negedge clk);
    opA = a; opB = b; hashKey = k; checkMode = m; expectVal = e; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R7", "busy after start", 64'(busy), 64'd1);
    chk(digest == 64'd0 && mismatch == 1'b0, "R9", "cleared on start", digest, 64'd0);
    // R7: operands changed after acceptance must not matter
    opA = {$urandom, $urandom}; opB = {$urandom, $urandom};
    hashKey = {$urandom, $urandom}; checkMode = ~m; expectVal = ~e;
    c = 0;
    while (c < 60) begin
      @(negedge clk);
      c++;
      if (poke && c == 5) start = 1'b1;   // R8: start while busy
      if (poke && c == 6) start = 1'b0;
      if (done) break;
    end
    chk(c == 33, poke ? "R8" : "R7", "done latency", 64'(c), 64'd33);
    chk(digest == refD, "R2 R3 R4", "digest", digest, refD);
    if (m)
      chk(mismatch == (refD != e), "R5", "check-mode flag", 64'(mismatch), 64'(refD != e));
    else
      chk(mismatch == 1'b0, "R6", "store-mode flag", 64'(mismatch), 64'd0);
    held = digest;
    heldM = mismatch;
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R7", "done is a pulse", 64'(done), 64'd0);
    chk(digest == held && mismatch == heldM, "R9", "results hold", digest, held);
  endtask

  initial begin
    logic [63:0] a, b, k, d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && mismatch == 0 && digest == 0, "R1", "reset state", digest, 64'd0);
    rstN = 1'b1;
    // directed cases
    doOp(64'd0, 64'd0, 64'd0, 1'b0, 64'd0, 0);
    doOp('1, '1, '1, 1'b0, 64'hDEAD, 0);
    a = 64'h0123456789ABCDEF; b = 64'hFEDCBA9876543210; k = 64'h0F1E2D3C4B5A6978;
    d = refHash(a, b, k);
    doOp(a, b, k, 1'b1, d, 0);                 // R5 match
    doOp(a, b, k, 1'b1, d ^ 64'h1, 0);         // R5 single-bit miss
    doOp(a, b, k, 1'b1, d ^ 64'h8000_0000_0000_0000, 0);
    doOp(a, b, k, 1'b0, ~d, 0);                // R6 store ignores expected value
    doOp(a, b, k, 1'b1, d, 1);                 // R8 start while busy
    // random cases
    for (int i = 0; i < 40; i++) begin
      logic m;
      a = {$urandom, $urandom}; b = {$urandom, $urandom}; k = {$urandom, $urandom};
      m = 1'($urandom);
      d = refHash(a, b, k);
      if ($urandom % 2) d = d ^ (64'd1 << ($urandom % 64));
      doOp(a, b, k, m, d, ($urandom % 5) == 0);
    end
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule